// File: doc/BRIEF.md
# Register Rename Map with Move Elimination and Zero Tracking

This block is the register alias table at the front of a small out-of-order core. Each cycle it takes a group of decoded ops (six by default). For each op it looks up the physical locations of the architectural source registers and gives the destination a new location. Fresh locations come from an external free list. The free list presents up to one tag per slot together with a count of how many of those tags are valid, and the map reports how many it consumed.

Two kinds of op need no physical register and no execution slot:
- A register-to-register move points its destination's map entry at the source's current location.
- A zeroing idiom sets a per-entry zero flag. A register whose flag is set owns no physical register, and its readers receive a constant-zero marker instead of a tag.

Because moves let several architectural registers share one physical register, a committed map and a per-tag reference count track ownership. A tag is handed back to the free list only when its last committed mapping is overwritten. A flush copies the committed map over the speculative map in a single cycle.

Top module: `ren_map`

## Requirements
- R1: After reset every architectural register is in the zero state, so every source read returns zero flag 1 and tag 0. No output is valid and no tag is freed.
- R2: An op of kind code 0 (compute, with a destination) takes the free-list tag `fl_tags` slice k. Here k counts the valid code-0 ops in lower slots of the same group. `fl_take` equals the number of valid code-0 ops when the group is accepted and is 0 otherwise.
- R3: Sources read the speculative map. A source naming a register written by a lower valid slot of the same group sees that slot's new mapping.
- R4: An op of kind code 1 (move) copies the mapping of `src_a`, both flag and tag, into its destination. It consumes no free-list tag, and its `src_b` is reported as the zero marker.
- R5: An op of kind code 2 (zeroing idiom) gives its destination zero flag 1 and tag 0. It consumes no tag, and both of its sources are reported as the zero marker, so it carries no dependence.
- R6: A source whose map entry is in the zero state is reported with zero flag 1 and tag 0.
- R7: When the valid code-0 ops in a group outnumber `fl_count`, the whole group is refused. `grp_accept` is 0, no slot is renamed, and the map is unchanged.
- R8: `out_dst_wr` is 1 for kind codes 0, 1 and 2 and 0 for kind code 3 (compute, no destination). `out_exec` is 1 only for kind codes 0 and 3.
- R9: A commit writes its mapping into the committed map. A physical tag is reported on `free_tag` with `free_valid`, one cycle after the commit, only when that commit removes the tag's last committed reference.
- R10: A flush refuses the group presented in the same cycle and restores the speculative map from the committed map, including a commit made in the flush cycle.
- R11: Renamed results of an accepted group appear on the outputs one clock after acceptance, with `out_valid` equal to the slots' `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | GROUP | Slot holds an op |
| in_kind | input | 2*GROUP | Per slot: 0 compute with destination, 1 move, 2 zeroing idiom, 3 compute without destination |
| in_src_a | input | AW*GROUP | First source register per slot |
| in_src_b | input | AW*GROUP | Second source register per slot |
| in_dst | input | AW*GROUP | Destination register per slot |
| fl_count | input | CW | Number of valid tags offered by the free list |
| fl_tags | input | TW*GROUP | Offered tags, lowest slice first |
| grp_accept | output | 1 | Group is renamed this cycle |
| fl_take | output | CW | Tags consumed this cycle |
| flush | input | 1 | Restore speculative map from committed map |
| cm_valid | input | 1 | One destination mapping commits |
| cm_arch | input | AW | Committed architectural register |
| cm_zero | input | 1 | Committed mapping is the zero state |
| cm_tag | input | TW | Committed physical tag |
| out_valid | output | GROUP | Renamed slot valid |
| out_exec | output | GROUP | Slot needs a scheduler and execution slot |
| out_dst_wr | output | GROUP | Slot writes a destination mapping |
| out_src_a_zero | output | GROUP | First source is the zero marker |
| out_src_a_tag | output | TW*GROUP | First source tag |
| out_src_b_zero | output | GROUP | Second source is the zero marker |
| out_src_b_tag | output | TW*GROUP | Second source tag |
| out_dst_zero | output | GROUP | Destination mapping is zero state |
| out_dst_tag | output | TW*GROUP | Destination mapping tag |
| free_valid | output | 1 | A tag is returned to the free list |
| free_tag | output | TW | Returned tag |

## Verification
The bench aims at chains inside one group: a compute op followed by a move of its result, then a reader of the moved register, then a zeroing of the first. A map without the intra-group forward would hand the last readers stale tags. Groups are offered one tag fewer than they need. A renamer that renamed part of a group would consume tags and move the map even though `grp_accept` stays low.

Commits of moves that share a tag check the reference counting. A design that frees on the first overwrite would return a tag that is still mapped, and one that never frees would run the pool dry. Flushes that land in the same cycle as a commit check that the restored map includes that commit. The following group's source tags reveal a restore that lost it.

// File: rtl/ren_map.sv
module ren_map #(
  parameter int GROUP = 6,
  parameter int ARCH  = 38,
  parameter int PHYS  = 180,
  localparam int AW = $clog2(ARCH),
  localparam int TW = $clog2(PHYS),
  localparam int CW = $clog2(GROUP + 1),
  localparam int RW = $clog2(ARCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP-1:0]      in_valid,
  input  logic [2*GROUP-1:0]    in_kind,
  input  logic [AW*GROUP-1:0]   in_src_a,
  input  logic [AW*GROUP-1:0]   in_src_b,
  input  logic [AW*GROUP-1:0]   in_dst,
  input  logic [CW-1:0]         fl_count,
  input  logic [TW*GROUP-1:0]   fl_tags,
  output logic                  grp_accept,
  output logic [CW-1:0]         fl_take,
  input  logic                  flush,
  input  logic                  cm_valid,
  input  logic [AW-1:0]         cm_arch,
  input  logic                  cm_zero,
  input  logic [TW-1:0]         cm_tag,
  output logic [GROUP-1:0]      out_valid,
  output logic [GROUP-1:0]      out_exec,
  output logic [GROUP-1:0]      out_dst_wr,
  output logic [GROUP-1:0]      out_src_a_zero,
  output logic [TW*GROUP-1:0]   out_src_a_tag,
  output logic [GROUP-1:0]      out_src_b_zero,
  output logic [TW*GROUP-1:0]   out_src_b_tag,
  output logic [GROUP-1:0]      out_dst_zero,
  output logic [TW*GROUP-1:0]   out_dst_tag,
  output logic                  free_valid,
  output logic [TW-1:0]         free_tag
);

  localparam int EW = TW + 1;
  localparam logic [TW:0] ZMARK = {1'b1, {TW{1'b0}}};

  logic [TW:0]   smap   [ARCH];
  logic [TW:0]   cmap   [ARCH];
  logic [TW:0]   work   [ARCH];
  logic [RW-1:0] refcnt [PHYS];

  logic [CW-1:0]       need;
  logic [GROUP-1:0]    n_exec, n_wr;
  logic [EW*GROUP-1:0] n_sa, n_sb, n_dst;

  always_comb begin
    need = '0;
    for (int i = 0; i < GROUP; i++)
      if (in_valid[i] && in_kind[2*i +: 2] == 2'd0) need = need + 1'b1;
  end

  assign grp_accept = !flush && (need <= fl_count);
  assign fl_take    = grp_accept ? need : '0;

  always_comb begin : walk
    logic [TW:0] ea, eb, ed;
    int k;
    k = 0;
    for (int a = 0; a < ARCH; a++) work[a] = smap[a];
    for (int i = 0; i < GROUP; i++) begin
      ea = work[in_src_a[AW*i +: AW]];
      eb = work[in_src_b[AW*i +: AW]];
      ed = ZMARK;
      n_exec[i] = 1'b0;
      n_wr[i]   = 1'b1;
      unique case (in_kind[2*i +: 2])
        2'd0: begin
          ed = {1'b0, fl_tags[TW*k +: TW]};
          n_exec[i] = 1'b1;
        end
        2'd1: begin
          eb = ZMARK;
          ed = ea;
        end
        2'd2: begin
          ea = ZMARK;
          eb = ZMARK;
        end
        default: begin
          n_exec[i] = 1'b1;
          n_wr[i]   = 1'b0;
        end
      endcase
      if (in_valid[i]) begin
        if (n_wr[i]) work[in_dst[AW*i +: AW]] = ed;
        if (in_kind[2*i +: 2] == 2'd0) k = k + 1;
      end
      n_sa[EW*i +: EW]  = ea;
      n_sb[EW*i +: EW]  = eb;
      n_dst[EW*i +: EW] = ed;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= '0;
    else        out_valid <= grp_accept ? in_valid : '0;

  always_ff @(posedge clk) begin
    out_exec   <= n_exec;
    out_dst_wr <= n_wr;
    for (int i = 0; i < GROUP; i++) begin
      out_src_a_zero[i]         <= n_sa[EW*i + TW];
      out_src_a_tag[TW*i +: TW] <= n_sa[EW*i +: TW];
      out_src_b_zero[i]         <= n_sb[EW*i + TW];
      out_src_b_tag[TW*i +: TW] <= n_sb[EW*i +: TW];
      out_dst_zero[i]           <= n_dst[EW*i + TW];
      out_dst_tag[TW*i +: TW]   <= n_dst[EW*i +: TW];
    end
  end

  logic [TW:0] cm_new, cm_old;
  logic        old_live, new_live, cm_same;

  assign cm_new   = cm_zero ? ZMARK : {1'b0, cm_tag};
  assign cm_old   = cmap[cm_arch];
  assign old_live = !cm_old[TW];
  assign new_live = !cm_zero;
  assign cm_same  = old_live && new_live && (cm_old[TW-1:0] == cm_tag);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int a = 0; a < ARCH; a++) smap[a] <= ZMARK;
    end else if (flush) begin
      for (int a = 0; a < ARCH; a++) smap[a] <= cmap[a];
      if (cm_valid) smap[cm_arch] <= cm_new;
    end else if (grp_accept) begin
      for (int a = 0; a < ARCH; a++) smap[a] <= work[a];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int a = 0; a < ARCH; a++) cmap[a] <= ZMARK;
      for (int p = 0; p < PHYS; p++) refcnt[p] <= '0;
      free_valid <= 1'b0;
      free_tag   <= '0;
    end else begin
      free_valid <= 1'b0;
      if (cm_valid) begin
        cmap[cm_arch] <= cm_new;
        if (new_live && !cm_same) refcnt[cm_tag] <= refcnt[cm_tag] + 1'b1;
        if (old_live && !cm_same) begin
          refcnt[cm_old[TW-1:0]] <= refcnt[cm_old[TW-1:0]] - 1'b1;
          free_valid <= (refcnt[cm_old[TW-1:0]] == RW'(1));
          free_tag   <= cm_old[TW-1:0];
        end
      end
    end

endmodule

module ren_map_chk #(
  parameter int GROUP = 6,
  parameter int ARCH  = 38,
  parameter int PHYS  = 180,
  localparam int TW = $clog2(PHYS),
  localparam int CW = $clog2(GROUP + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                grp_accept,
  input logic [CW-1:0]       fl_take,
  input logic [CW-1:0]       fl_count,
  input logic                cm_valid,
  input logic                cm_zero,
  input logic [TW-1:0]       cm_tag,
  input logic [GROUP-1:0]    out_valid,
  input logic [GROUP-1:0]    out_src_a_zero,
  input logic [TW*GROUP-1:0] out_src_a_tag,
  input logic                free_valid,
  input logic [TW-1:0]       free_tag
);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> out_valid == '0);

  assert_refused_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_accept |=> out_valid == '0);

  assert_take_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_take <= fl_count);

  assert_free_follows_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> $past(cm_valid));

  assert_free_not_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !$past(cm_zero) |-> free_tag != $past(cm_tag));

  for (genvar i = 0; i < GROUP; i++) begin : g_slot
    assert_zero_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] && out_src_a_zero[i] |-> out_src_a_tag[TW*i +: TW] == '0);
  end

endmodule

bind ren_map ren_map_chk #(.GROUP(GROUP), .ARCH(ARCH), .PHYS(PHYS)) u_chk (.*);

// File: tb/ren_map_tb.sv
module ren_map_tb;
  localparam int G  = 4;
  localparam int A  = 8;
  localparam int P  = 32;
  localparam int AW = $clog2(A);
  localparam int TW = $clog2(P);
  localparam int CW = $clog2(G + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [G-1:0] in_valid;
  logic [2*G-1:0] in_kind;
  logic [AW*G-1:0] in_src_a, in_src_b, in_dst;
  logic [CW-1:0] fl_count;
  logic [TW*G-1:0] fl_tags;
  logic grp_accept;
  logic [CW-1:0] fl_take;
  logic flush, cm_valid, cm_zero;
  logic [AW-1:0] cm_arch;
  logic [TW-1:0] cm_tag;
  logic [G-1:0] out_valid, out_exec, out_dst_wr, out_src_a_zero, out_src_b_zero, out_dst_zero;
  logic [TW*G-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag;
  logic free_valid;
  logic [TW-1:0] free_tag;

  ren_map #(.GROUP(G), .ARCH(A), .PHYS(P)) u_dut (.*);

  int n_chk = 0, n_err = 0;
  int pool[$];
  int pa[$], pz[$], pt[$], pf[$];
  int spz[A], spt[A], coz[A], cot[A], rc[P];
  int v[G], kd[G], s1[G], s2[G], dd[G];
  int unsigned seed = 32'h1234abcd;

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  // ctx: 0 normal, 1 first group after a flush, 2 first group after reset
  task automatic step(input bit fl, input bit want_cm, input bit stall, input int ctx);
    int need, fc, k, ca, cz, ct, oz, ot;
    int ez_a[G], et_a[G], ez_b[G], et_b[G], ez_d[G], et_d[G];
    int wz[A], wt[A];
    bit acc, cmv, same, freed, ev;
    string la, lb, ld;
    @(negedge clk);
    need = 0;
    for (int i = 0; i < G; i++) if (v[i] != 0 && kd[i] == 0) need++;
    fc = (pool.size() < G) ? pool.size() : G;
    if (stall && need > 0) fc = need - 1;
    for (int i = 0; i < G; i++) begin
      in_valid[i] = (v[i] != 0);
      in_kind[2*i +: 2] = kd[i][1:0];
      in_src_a[AW*i +: AW] = s1[i][AW-1:0];
      in_src_b[AW*i +: AW] = s2[i][AW-1:0];
      in_dst[AW*i +: AW] = dd[i][AW-1:0];
      fl_tags[TW*i +: TW] = (i < fc && i < pool.size()) ? pool[i][TW-1:0] : '0;
    end
    fl_count = fc[CW-1:0];
    cmv = want_cm && pa.size() > 0;
    ca = 0; cz = 1; ct = 0;
    if (cmv) begin ca = pa[0]; cz = pz[0]; ct = pt[0]; end
    cm_valid = cmv; cm_arch = ca[AW-1:0]; cm_zero = cz[0]; cm_tag = ct[TW-1:0];
    flush = fl;
    #1;
    acc = !fl && need <= fc;
    chk("R7 accept", grp_accept, acc);
    chk("R2 take", fl_take, acc ? need : 0);
    for (int a = 0; a < A; a++) begin wz[a] = spz[a]; wt[a] = spt[a]; end
    k = 0;
    for (int i = 0; i < G; i++) begin
      ez_a[i] = wz[s1[i]]; et_a[i] = wt[s1[i]];
      ez_b[i] = wz[s2[i]]; et_b[i] = wt[s2[i]];
      ez_d[i] = 1; et_d[i] = 0;
      case (kd[i])
        0: begin ez_d[i] = 0; et_d[i] = (k < pool.size()) ? pool[k] : 0; end
        1: begin ez_b[i] = 1; et_b[i] = 0; ez_d[i] = ez_a[i]; et_d[i] = et_a[i]; end
        2: begin ez_a[i] = 1; et_a[i] = 0; ez_b[i] = 1; et_b[i] = 0; end
        default: ;
      endcase
      if (v[i] != 0) begin
        if (kd[i] != 3) begin wz[dd[i]] = ez_d[i]; wt[dd[i]] = et_d[i]; end
        if (kd[i] == 0) k++;
      end
    end
    oz = coz[ca]; ot = cot[ca];
    same = (oz == 0) && (cz == 0) && (ot == ct);
    freed = cmv && (oz == 0) && !same && rc[ot] == 1;
    @(posedge clk);
    #2;
    for (int i = 0; i < G; i++) begin
      ev = acc && v[i] != 0;
      chk(fl ? "R10 valid" : (acc ? "R11 valid" : "R7 valid"), out_valid[i], ev);
      if (ev) begin
        if (ctx == 2) la = "R1 src";
        else if (kd[i] == 2) la = "R5 src";
        else if (ctx == 1) la = "R10 src";
        else if (ez_a[i] != 0) la = "R6 src";
        else la = "R3 src";
        lb = (kd[i] == 1) ? "R4 srcb" : la;
        chk(la, out_src_a_zero[i], ez_a[i]);
        chk(la, out_src_a_tag[TW*i +: TW], et_a[i]);
        chk(lb, out_src_b_zero[i], ez_b[i]);
        chk(lb, out_src_b_tag[TW*i +: TW], et_b[i]);
        if (kd[i] != 3) begin
          ld = (kd[i] == 0) ? "R2 dst" : (kd[i] == 1) ? "R4 dst" : "R5 dst";
          chk(ld, out_dst_zero[i], ez_d[i]);
          chk(ld, out_dst_tag[TW*i +: TW], et_d[i]);
        end
        chk("R8 wr", out_dst_wr[i], kd[i] != 3);
        chk("R8 exec", out_exec[i], kd[i] == 0 || kd[i] == 3);
      end
    end
    chk("R9 free", free_valid, freed);
    if (freed) chk("R9 tag", free_tag, ot);
    if (cmv) begin
      if (cz == 0 && !same) rc[ct]++;
      if (oz == 0 && !same) rc[ot]--;
      coz[ca] = cz; cot[ca] = (cz != 0) ? 0 : ct;
      void'(pa.pop_front()); void'(pz.pop_front()); void'(pt.pop_front()); void'(pf.pop_front());
      if (freed) pool.push_back(ot);
    end
    if (fl) begin
      for (int a = 0; a < A; a++) begin spz[a] = coz[a]; spt[a] = cot[a]; end
      foreach (pf[j]) if (pf[j] != 0) pool.push_back(pt[j]);
      pa.delete(); pz.delete(); pt.delete(); pf.delete();
    end else if (acc) begin
      for (int a = 0; a < A; a++) begin spz[a] = wz[a]; spt[a] = wt[a]; end
      for (int n = 0; n < need; n++) void'(pool.pop_front());
      for (int i = 0; i < G; i++)
        if (v[i] != 0 && kd[i] != 3) begin
          pa.push_back(dd[i]); pz.push_back(ez_d[i]); pt.push_back(et_d[i]);
          pf.push_back(kd[i] == 0);
        end
    end
  endtask

  task automatic set_op(input int i, input int vv, input int kk, input int a, input int b, input int d);
    v[i] = vv; kd[i] = kk; s1[i] = a; s2[i] = b; dd[i] = d;
  endtask

  initial begin
    bit after_fl, fl;
    rst_n = 1'b0;
    in_valid = '0; in_kind = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
    fl_count = '0; fl_tags = '0; flush = 1'b0;
    cm_valid = 1'b0; cm_arch = '0; cm_zero = 1'b0; cm_tag = '0;
    for (int p = 0; p < P; p++) pool.push_back(p);
    for (int a = 0; a < A; a++) begin spz[a] = 1; spt[a] = 0; coz[a] = 1; cot[a] = 0; end
    for (int p = 0; p < P; p++) rc[p] = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid", out_valid, 0);
    chk("R1 free", free_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < G; i++) set_op(i, 1, 3, 2*i, 2*i+1, 0);
    step(0, 0, 0, 2);
    // chain inside one group: compute, move, reader of the move, zeroing
    set_op(0, 1, 0, 0, 0, 1);
    set_op(1, 1, 1, 1, 0, 2);
    set_op(2, 1, 0, 2, 1, 3);
    set_op(3, 1, 2, 1, 1, 1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    for (int n = 0; n < 4; n++) step(0, 1, 0, 0);
    after_fl = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < G; i++)
        set_op(i, (rnd() % 3) == 0, rnd() % 4, rnd() % A, rnd() % A, rnd() % A);
      fl = (rnd() % 23) == 0;
      step(fl, (rnd() % 4) != 0, (rnd() % 7) == 0, after_fl ? 1 : 0);
      after_fl = fl;
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule